// File: doc/BRIEF.md
# Power-Up Reset and Clock Bring-Up Sequencer

This block decides when a processor may leave reset after power is applied or after the board-level reset line goes inactive. It runs two timed phases, one after the other, using one counter. The first phase waits for the crystal oscillator to settle, and its length is picked from a small set of powers of two. The second phase releases the PLL from its stopped state and waits out the PLL lock time. Only after both phases does the block drop the internal processor reset.

The processor then starts in clock-through mode, where its clock is the oscillator clock divided by eight. Moving to the PLL clock is left to software. Software first picks the divide ratio and then raises a PLL request. After that the divider is frozen. A later attempt to change it is discarded and raises a sticky error flag.

The oscillator, the PLL and the glitch-free clock multiplexer sit outside this block. The block drives only their control lines, and it reports its current phase on a two-bit status output.

Top module: `boot_clock_sequencer`

## Requirements
- R1: While `ext_rst_n` is low the outputs are `seq_phase`=00, `pll_stop`=1, `cpu_rst_n`=0, `clk_sel_pll`=0, `cpu_div_sel`=3 and `div_err`=0. After `ext_rst_n` rises, `seq_phase` leaves 00 on the third rising clock edge: two synchronizer stages plus one sequencer step.
- R2: The stabilization phase (`seq_phase`=01) lasts exactly 2^(STAB_MIN_LOG2+`stab_sel`) clock cycles. `stab_sel` is captured when the reset phase is left, and later changes to it have no effect. `pll_stop` stays 1 through the reset and stabilization phases.
- R3: The lock phase (`seq_phase`=10) follows the stabilization phase and lasts exactly 2^LOCK_LOG2 cycles. During it `pll_stop`=0 and `cpu_rst_n`=0.
- R4: After the lock phase the block enters the run phase (`seq_phase`=11) and sets `cpu_rst_n`=1. The shared counter reads zero in this phase. The phase codes are 00 reset, 01 stabilizing, 10 locking and 11 running.
- R5: On entry to the run phase, `clk_sel_pll`=0 (clock-through) and `cpu_div_sel`=3. The divider codes are 0 for /1, 1 for /2, 2 for /4 and 3 for /8.
- R6: In the run phase with clock-through selected, a one-cycle `div_wr` pulse loads `div_val` into `cpu_div_sel` at the next clock edge.
- R7: A one-cycle `pll_mode_req` pulse in the run phase sets `clk_sel_pll`=1 at the next clock edge. It stays 1 until reset.
- R8: A `div_wr` pulse while `clk_sel_pll`=1 leaves `cpu_div_sel` unchanged and sets `div_err`=1. `div_err` stays 1 until reset.
- R9: Driving `ext_rst_n` low in any phase returns every output to its R1 reset value at once, without waiting for a clock edge.
- R10: `div_wr` and `pll_mode_req` pulses given before the run phase are ignored.
- R11: The phase only moves forward one step at a time (00, 01, 10, 11). Once it reaches 11 it stays there until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_osc | input | 1 | Oscillator clock |
| ext_rst_n | input | 1 | External reset, active low, asynchronous |
| stab_sel | input | SEL_W | Stabilization interval select |
| pll_mode_req | input | 1 | Software pulse requesting the PLL clock |
| div_wr | input | 1 | Software pulse writing the CPU divider |
| div_val | input | 2 | Divider code to write |
| pll_stop | output | 1 | Holds the PLL stopped when 1 |
| cpu_rst_n | output | 1 | Internal processor reset, active low |
| clk_sel_pll | output | 1 | Clock select: 0 clock-through, 1 PLL |
| cpu_div_sel | output | 2 | CPU clock divide code |
| div_err | output | 1 | Sticky flag for a rejected divider write |
| seq_phase | output | 2 | Current sequencer phase |

## Verification
The hardest situations to reach from the ports are a reset that lands partway through a timed phase and a divider write that arrives after the PLL switch. Both come only after a full timed bring-up. The bench therefore instantiates the block with short intervals and polls `seq_phase` to find the cycle where each phase starts. It asserts reset in the middle of the lock phase and again in PLL mode, checking the outputs before any clock edge follows. It also changes `stab_sel` and sends software pulses during stabilization to show that they have no effect on the measured phase lengths or the final clock state.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

    localparam int DIV_W = 2;

    typedef enum logic [1:0] {
        PH_RESET = 2'b00,
        PH_STAB  = 2'b01,
        PH_LOCK  = 2'b10,
        PH_RUN   = 2'b11
    } phase_e;

    // Divide code used right after bring-up: oscillator / 8
    localparam logic [DIV_W-1:0] DIV_CODE_BY8 = 2'b11;

endpackage

// File: rtl/bcs_rst_sync.sv
module bcs_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic rst_n_o
);
    logic [STAGES-1:0] chain_d;
    logic [STAGES-1:0] chain_q;

    // Assert asynchronously, release through STAGES flops
    always_comb begin
        chain_d = {chain_q[STAGES-2:0], 1'b1};
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain_q <= '0;
        else         chain_q <= chain_d;
    end

    assign rst_n_o = chain_q[STAGES-1];

    // R1: a released output can only follow a released first stage
    assert_sync_order_R1: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(rst_n_o) |-> $past(chain_q[0]));
endmodule

// File: rtl/bcs_phase_fsm.sv
module bcs_phase_fsm
    import bcs_pkg::*;
#(
    parameter int SEL_W         = 2,
    parameter int STAB_MIN_LOG2 = 12,
    parameter int LOCK_LOG2     = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] stab_sel,
    output phase_e           phase_o,
    output logic             pll_stop_o,
    output logic             cpu_rst_n_o
);
    localparam int STAB_MAX_LOG2 = STAB_MIN_LOG2 + (1 << SEL_W) - 1;
    localparam int CNT_W = ((STAB_MAX_LOG2 > LOCK_LOG2) ? STAB_MAX_LOG2 : LOCK_LOG2) + 1;
    localparam logic [CNT_W-1:0] CNT_ONE   = CNT_W'(1);
    localparam logic [CNT_W-1:0] LOCK_LAST = (CNT_ONE << LOCK_LOG2) - CNT_ONE;

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
        logic [SEL_W-1:0] sel;
        logic             pll_stop;
        logic             cpu_rst_n;
    } fsm_t;

    localparam fsm_t FSM_RESET = '{
        phase:     PH_RESET,
        cnt:       '0,
        sel:       '0,
        pll_stop:  1'b1,
        cpu_rst_n: 1'b0
    };

    fsm_t st_d;
    fsm_t st_q;

    function automatic logic [CNT_W-1:0] stab_last(input logic [SEL_W-1:0] s);
        return (CNT_ONE << (STAB_MIN_LOG2 + int'(s))) - CNT_ONE;
    endfunction

    always_comb begin
        st_d = st_q;
        unique case (st_q.phase)
            PH_RESET: begin
                st_d.phase = PH_STAB;
                st_d.cnt   = '0;
                st_d.sel   = stab_sel;
            end
            PH_STAB: begin
                if (st_q.cnt == stab_last(st_q.sel)) begin
                    st_d.phase = PH_LOCK;
                    st_d.cnt   = '0;
                end else begin
                    st_d.cnt = st_q.cnt + CNT_ONE;
                end
            end
            PH_LOCK: begin
                if (st_q.cnt == LOCK_LAST) begin
                    st_d.phase = PH_RUN;
                    st_d.cnt   = '0;
                end else begin
                    st_d.cnt = st_q.cnt + CNT_ONE;
                end
            end
            PH_RUN: begin
                st_d.cnt = '0;
            end
            default: st_d = FSM_RESET;
        endcase
        // Control outputs are registered from the next phase: no decode glitches
        st_d.pll_stop  = (st_d.phase == PH_RESET) || (st_d.phase == PH_STAB);
        st_d.cpu_rst_n = (st_d.phase == PH_RUN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= FSM_RESET;
        else        st_q <= st_d;
    end

    assign phase_o     = st_q.phase;
    assign pll_stop_o  = st_q.pll_stop;
    assign cpu_rst_n_o = st_q.cpu_rst_n;

    // R11: phase only steps forward by one
    assert_phase_order_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase != $past(st_q.phase)) |-> (st_q.phase == phase_e'($past(st_q.phase) + 2'd1)));

    // R11: run phase is terminal until reset
    assert_run_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_RUN) |=> (st_q.phase == PH_RUN));

    // R4: shared counter reads zero once running
    assert_cnt_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_RUN) |-> (st_q.cnt == '0));

    // R2: captured select does not move during stabilization
    assert_sel_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_STAB && $past(st_q.phase) == PH_STAB) |-> $stable(st_q.sel));

    // R2: PLL held stopped while stabilizing
    assert_pll_stopped_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_STAB) |-> st_q.pll_stop);

    // R3: lock count never runs past its limit
    assert_lock_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_LOCK) |-> (st_q.cnt <= LOCK_LAST && !st_q.cpu_rst_n));
endmodule

// File: rtl/bcs_clk_ctrl.sv
module bcs_clk_ctrl
    import bcs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             pll_req_i,
    input  logic             div_wr_i,
    input  logic [DIV_W-1:0] div_val_i,
    output logic             pll_sel_o,
    output logic [DIV_W-1:0] div_sel_o,
    output logic             div_err_o
);
    typedef struct packed {
        logic             pll_sel;
        logic [DIV_W-1:0] div;
        logic             err;
    } ctl_t;

    localparam ctl_t CTL_RESET = '{pll_sel: 1'b0, div: DIV_CODE_BY8, err: 1'b0};

    ctl_t ctl_d;
    ctl_t ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (run_i) begin
            if (div_wr_i) begin
                if (ctl_q.pll_sel) ctl_d.err = 1'b1;   // divider frozen in PLL mode
                else               ctl_d.div = div_val_i;
            end
            if (pll_req_i) ctl_d.pll_sel = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= CTL_RESET;
        else        ctl_q <= ctl_d;
    end

    assign pll_sel_o = ctl_q.pll_sel;
    assign div_sel_o = ctl_q.div;
    assign div_err_o = ctl_q.err;

    // R8: divider frozen once PLL is selected
    assert_div_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.pll_sel |=> $stable(ctl_q.div));

    // R8: error flag is sticky
    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.err |=> ctl_q.err);

    // R8: error only exists in PLL mode
    assert_err_needs_pll_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.err |-> ctl_q.pll_sel);

    // R7 / R10: PLL selection only taken up while running
    assert_pll_only_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_q.pll_sel) |-> $past(run_i));

    // R7: PLL selection kept until reset
    assert_pll_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.pll_sel |=> ctl_q.pll_sel);
endmodule

// File: rtl/boot_clock_sequencer.sv
module boot_clock_sequencer
    import bcs_pkg::*;
#(
    parameter int SEL_W         = 2,
    parameter int STAB_MIN_LOG2 = 12,
    parameter int LOCK_LOG2     = 15
) (
    input  logic             clk_osc,
    input  logic             ext_rst_n,
    input  logic [SEL_W-1:0] stab_sel,
    input  logic             pll_mode_req,
    input  logic             div_wr,
    input  logic [DIV_W-1:0] div_val,
    output logic             pll_stop,
    output logic             cpu_rst_n,
    output logic             clk_sel_pll,
    output logic [DIV_W-1:0] cpu_div_sel,
    output logic             div_err,
    output logic [1:0]       seq_phase
);
    logic   rst_sync_n;
    phase_e phase;

    bcs_rst_sync #(.STAGES(2)) u_sync (
        .clk     (clk_osc),
        .arst_n  (ext_rst_n),
        .rst_n_o (rst_sync_n)
    );

    bcs_phase_fsm #(
        .SEL_W         (SEL_W),
        .STAB_MIN_LOG2 (STAB_MIN_LOG2),
        .LOCK_LOG2     (LOCK_LOG2)
    ) u_fsm (
        .clk         (clk_osc),
        .rst_n       (rst_sync_n),
        .stab_sel    (stab_sel),
        .phase_o     (phase),
        .pll_stop_o  (pll_stop),
        .cpu_rst_n_o (cpu_rst_n)
    );

    bcs_clk_ctrl u_clk (
        .clk       (clk_osc),
        .rst_n     (rst_sync_n),
        .run_i     (cpu_rst_n),
        .pll_req_i (pll_mode_req),
        .div_wr_i  (div_wr),
        .div_val_i (div_val),
        .pll_sel_o (clk_sel_pll),
        .div_sel_o (cpu_div_sel),
        .div_err_o (div_err)
    );

    assign seq_phase = phase;

    // R4: processor never leaves reset with the PLL stopped
    assert_run_pll_on_R4: assert property (@(posedge clk_osc) disable iff (!rst_sync_n)
        cpu_rst_n |-> !pll_stop);

    // R10: no PLL selection while processor is held in reset
    assert_idle_clock_R10: assert property (@(posedge clk_osc) disable iff (!rst_sync_n)
        !cpu_rst_n |-> !clk_sel_pll);
endmodule

// File: tb/boot_clock_sequencer_test.sv
module boot_clock_sequencer_test;
    localparam int SEL_W = 2;
    localparam int SMIN  = 3;
    localparam int LLOG  = 4;

    logic       clk = 1'b0;
    logic       ext_rst_n = 1'b0;
    logic [1:0] stab_sel = 2'd0;
    logic       pll_mode_req = 1'b0;
    logic       div_wr = 1'b0;
    logic [1:0] div_val = 2'd0;
    logic       pll_stop, cpu_rst_n, clk_sel_pll, div_err;
    logic [1:0] cpu_div_sel, seq_phase;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    boot_clock_sequencer #(.SEL_W(SEL_W), .STAB_MIN_LOG2(SMIN), .LOCK_LOG2(LLOG)) uut (
        .clk_osc(clk), .ext_rst_n(ext_rst_n), .stab_sel(stab_sel),
        .pll_mode_req(pll_mode_req), .div_wr(div_wr), .div_val(div_val),
        .pll_stop(pll_stop), .cpu_rst_n(cpu_rst_n), .clk_sel_pll(clk_sel_pll),
        .cpu_div_sel(cpu_div_sel), .div_err(div_err), .seq_phase(seq_phase)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Packed outputs {phase,pll_stop,cpu_rst_n,clk_sel_pll,div,err}
    function automatic int outs();
        return int'({seq_phase, pll_stop, cpu_rst_n, clk_sel_pll, cpu_div_sel, div_err});
    endfunction
    localparam int RESET_OUTS = int'({2'b00, 1'b1, 1'b0, 1'b0, 2'b11, 1'b0});

    // Full bring-up from a released reset; optional pokes during stabilization
    task automatic boot(input logic [1:0] sel, input bit poke, input bit move_sel);
        int lat, n_stab, n_lock;
        bit stop_bad, rst_bad;
        stab_sel = sel;
        @(negedge clk);
        ext_rst_n = 1'b1;
        lat = 0;
        do begin @(negedge clk); lat++; end while (seq_phase == 2'b00 && lat < 50);
        chk("R1 release latency", lat, 3);
        n_stab = 0; stop_bad = 0;
        while (seq_phase == 2'b01 && n_stab < 5000) begin
            if (!pll_stop) stop_bad = 1;
            if (poke && n_stab == 0) begin div_wr = 1; div_val = 2'd0; pll_mode_req = 1; end
            if (n_stab == 1) begin div_wr = 0; pll_mode_req = 0; end
            if (move_sel && n_stab == 2) stab_sel = 2'd0;
            n_stab++;
            @(negedge clk);
        end
        chk("R2 stabilization length", n_stab, 1 << (SMIN + int'(sel)));
        chk("R2 pll_stop held while stabilizing", int'(stop_bad), 0);
        chk("R11 stab followed by lock", int'(seq_phase), 2);
        n_lock = 0; stop_bad = 0; rst_bad = 0;
        while (seq_phase == 2'b10 && n_lock < 5000) begin
            if (pll_stop) stop_bad = 1;
            if (cpu_rst_n) rst_bad = 1;
            n_lock++;
            @(negedge clk);
        end
        chk("R3 lock length", n_lock, 1 << LLOG);
        chk("R3 pll running in lock", int'(stop_bad), 0);
        chk("R3 cpu reset held in lock", int'(rst_bad), 0);
        chk("R4 run phase and cpu released", int'({seq_phase, cpu_rst_n}), int'({2'b11, 1'b1}));
        chk("R5 clock-through div8 after boot", int'({clk_sel_pll, cpu_div_sel}), int'({1'b0, 2'b11}));
        if (poke) chk("R10 early pokes ignored", int'(div_err), 0);
    endtask

    // Vectors: {div_wr, div_val[1:0], pll_req, exp_pll, exp_div[1:0], exp_err}
    localparam int NV = 7;
    localparam logic [7:0] VEC [NV] = '{
        8'b1_00_0_0_00_0,  // R6 write /1
        8'b1_10_0_0_10_0,  // R6 write /4
        8'b0_00_0_0_10_0,  // R6 idle hold
        8'b0_00_1_1_10_0,  // R7 switch to PLL
        8'b1_01_0_1_10_1,  // R8 write rejected
        8'b0_00_0_1_10_1,  // R8 flag sticky
        8'b0_00_1_1_10_1   // R7 repeat request no change
    };

    initial begin
        #1;
        // R1 reset state
        repeat (3) @(negedge clk);
        chk("R1 reset outputs", outs(), RESET_OUTS);

        boot(2'd0, 1'b1, 1'b0);

        for (int i = 0; i < NV; i++) begin
            {div_wr, div_val, pll_mode_req} = {VEC[i][7], VEC[i][6:5], VEC[i][4]};
            @(negedge clk);
            div_wr = 0; pll_mode_req = 0;
            chk("R6/R7/R8 vector pll_sel", int'(clk_sel_pll), int'(VEC[i][3]));
            chk("R6/R7/R8 vector div", int'(cpu_div_sel), int'(VEC[i][2:1]));
            chk("R8 vector div_err", int'(div_err), int'(VEC[i][0]));
        end

        // R9 async reset from PLL mode, checked before any clock edge
        ext_rst_n = 1'b0;
        #1;
        chk("R9 async reset from run/PLL", outs(), RESET_OUTS);

        // R2 select captured at start; later change has no effect
        boot(2'd2, 1'b0, 1'b1);

        // R9 reset in the middle of lock
        @(negedge clk);
        ext_rst_n = 1'b0;
        @(negedge clk);
        stab_sel = 2'd1;
        ext_rst_n = 1'b1;
        for (int k = 0; k < 200 && seq_phase != 2'b10; k++) @(negedge clk);
        repeat (3) @(negedge clk);
        chk("R9 reached lock before reset", int'(seq_phase), 2);
        ext_rst_n = 1'b0;
        #1;
        chk("R9 async reset from lock", outs(), RESET_OUTS);
        boot(2'd1, 1'b0, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #500000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule